// File: doc/BRIEF.md
# Frequency-Hop Synthesizer Ping-Pong Sequencer

This block sequences frequency hops for a time-division transceiver. Each hop frame is a transition period of programmable length followed at once by a dwell period of programmable length, both counted in clock cycles. The block tells the frequency synthesizers when to start tuning and which frequency word to use. It says which synthesizer feeds the radio during the dwell. It flags whether the dwell is usable, and it reports when a synthesizer did not lock in time.

When the block is enabled, it compares the transition length with a programmable synthesizer retune time and picks one of two modes. If the transition is long enough, it picks single-synthesizer retune mode: synthesizer 0 is retuned at the start of every frame and must lock before the transition ends. If the transition is too short, it picks dual-synthesizer alternating mode. In that mode, the synthesizer that has just served a dwell is retuned at the next frame start, while the other one takes over. The retuned synthesizer therefore has a whole transition, dwell and transition window to lock.

Frequency words arrive one per tune over a valid/ready handshake. A frame does not start until its word has been accepted. The first frame after enable preloads the synthesizers before the first dwell: both of them in alternating mode, one in retune mode.

Top module: `fh_pingpong_sched`

## Requirements
- R1: When the block is started from idle (enable high), it latches the transition length, the dwell length and the mode. Alternating mode (mux_mode=1) is chosen only when trans_len is strictly less than retune_time. Otherwise, retune mode (mux_mode=0) is chosen, and this includes the case where the two are equal.
- R2: After the frame's last word is accepted, the transition lasts trans_len cycles, counting from the next cycle. The dwell then lasts dwell_len cycles. A length of 0 behaves as 1.
- R3: active_sel is 0 in retune mode. In alternating mode, active_sel is 0 for the first dwell after a start, and it inverts at the end of every later transition.
- R4: In retune mode, every tune goes to synthesizer 0. In alternating mode, every tune after the preload goes to the synthesizer that was active in the previous dwell.
- R5: In alternating mode, the preload frame accepts two words: the first goes to synthesizer 0 and the second to synthesizer 1, and only then does the transition start. In retune mode, the preload frame accepts one word.
- R6: On the last transition cycle, the block samples the lock input of the synthesizer that is about to become active. If that input is low, dwell_valid stays low for the whole dwell and late_lock_err is set. If it is high, dwell_valid is high for exactly the dwell cycles.
- R7: late_lock_err stays set through later frames and through disable. It is cleared only when the block is next started from idle.
- R8: freq_ready is high only while the block waits for a word and enable is high. If freq_valid is low, the block waits in place and emits no strobe.
- R9: For each accepted word, the targeted synthesizer's tune_start pulses for exactly one cycle, in the cycle after acceptance. That synthesizer's tune_word then holds the word until its next strobe.
- R10: When enable is low at a clock edge, the block is idle from the next cycle: dwell_valid and freq_ready are low.
- R11: After reset, all strobes, words, active_sel, dwell_valid, late_lock_err and mux_mode are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; low returns to idle |
| trans_len | input | CNT_W | Transition length in cycles |
| dwell_len | input | CNT_W | Dwell length in cycles |
| retune_time | input | CNT_W | Synthesizer retune time in cycles, used to pick the mode |
| freq_valid | input | 1 | Next frequency word is valid |
| freq_word | input | FREQ_W | Next frequency word |
| freq_ready | output | 1 | Block accepts a word this cycle |
| pll_lock | input | 2 | Lock indication per synthesizer |
| tune_start | output | 2 | One-cycle tune strobe per synthesizer |
| tune_word | output | 2 x FREQ_W | Frequency word per synthesizer |
| active_sel | output | 1 | Synthesizer serving the current dwell |
| dwell_valid | output | 1 | Dwell is in progress with a locked synthesizer |
| late_lock_err | output | 1 | Sticky late-lock error |
| mux_mode | output | 1 | 1 = alternating mode, 0 = retune mode |

## Verification
The bench builds the block with CNT_W=6 and FREQ_W=12, so frames are a few cycles long. This lets many frame boundaries, mode toggles and preload sequences fit into a short run. The bench drives lengths of 0 and 1, a transition equal to the retune time, stalls of the word source, a synthesizer that never locks, and a disable in the middle of a dwell. A behavioural model with phase counters predicts every output on every cycle.

// File: rtl/fh_sched_pkg.sv
package fh_sched_pkg;

    localparam int PLL_CNT = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TUNE  = 2'd1,
        ST_TRANS = 2'd2,
        ST_DWELL = 2'd3
    } fh_state_e;

endpackage

// File: rtl/fh_frame_timer.sv
module fh_frame_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = (tmr_q.cnt == '0);

    // R2
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tmr_q.cnt != '0) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1));

endmodule

// File: rtl/fh_tune_issue.sv
module fh_tune_issue
    import fh_sched_pkg::*;
#(
    parameter int FREQ_W = 24
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            issue,
    input  logic                            target,
    input  logic [FREQ_W-1:0]               word,
    output logic [PLL_CNT-1:0]              tune_start,
    output logic [PLL_CNT-1:0][FREQ_W-1:0]  tune_word
);

    typedef struct packed {
        logic              strobe;
        logic [FREQ_W-1:0] word;
    } lane_t;

    for (genvar g = 0; g < PLL_CNT; g++) begin : g_lane
        lane_t lane_d, lane_q;
        logic  hit;

        assign hit = issue && (int'(target) == g);

        always_comb begin
            lane_d        = lane_q;
            lane_d.strobe = hit;
            if (hit) begin
                lane_d.word = word;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else begin
                lane_q <= lane_d;
            end
        end

        assign tune_start[g] = lane_q.strobe;
        assign tune_word[g]  = lane_q.word;

        // R9
        strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tune_start[g] |=> !tune_start[g]);

        // R9
        word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !tune_start[g] |-> $stable(tune_word[g]));
    end

    // R9
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tune_start));

endmodule

// File: rtl/fh_pingpong_sched.sv
module fh_pingpong_sched
    import fh_sched_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FREQ_W = 24
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            enable,
    input  logic [CNT_W-1:0]                trans_len,
    input  logic [CNT_W-1:0]                dwell_len,
    input  logic [CNT_W-1:0]                retune_time,
    input  logic                            freq_valid,
    input  logic [FREQ_W-1:0]               freq_word,
    output logic                            freq_ready,
    input  logic [PLL_CNT-1:0]              pll_lock,
    output logic [PLL_CNT-1:0]              tune_start,
    output logic [PLL_CNT-1:0][FREQ_W-1:0]  tune_word,
    output logic                            active_sel,
    output logic                            dwell_valid,
    output logic                            late_lock_err,
    output logic                            mux_mode
);

    typedef struct packed {
        fh_state_e        state;
        logic             mux;
        logic             pre;
        logic             second;
        logic             sel;
        logic             dv;
        logic             err;
        logic [CNT_W-1:0] tl;
        logic [CNT_W-1:0] dl;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             accept;
    logic             issue;
    logic             target;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             next_sel;

    function automatic logic [CNT_W-1:0] len_minus_one(input logic [CNT_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction

    assign freq_ready = (ctl_q.state == ST_TUNE) && enable;
    assign accept     = freq_ready && freq_valid;
    assign next_sel   = (ctl_q.pre || !ctl_q.mux) ? ctl_q.sel : ~ctl_q.sel;

    always_comb begin
        ctl_d    = ctl_q;
        issue    = 1'b0;
        target   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (!enable) begin
            ctl_d.state = ST_IDLE;
            ctl_d.dv    = 1'b0;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE: begin
                    ctl_d.mux    = (trans_len < retune_time);
                    ctl_d.tl     = trans_len;
                    ctl_d.dl     = dwell_len;
                    ctl_d.err    = 1'b0;
                    ctl_d.sel    = 1'b0;
                    ctl_d.pre    = 1'b1;
                    ctl_d.second = 1'b0;
                    ctl_d.dv     = 1'b0;
                    ctl_d.state  = ST_TUNE;
                end
                ST_TUNE: begin
                    if (accept) begin
                        issue  = 1'b1;
                        target = ctl_q.pre ? ctl_q.second
                                           : (ctl_q.mux ? ctl_q.sel : 1'b0);
                        if (ctl_q.mux && ctl_q.pre && !ctl_q.second) begin
                            ctl_d.second = 1'b1;
                        end else begin
                            ctl_d.state = ST_TRANS;
                            tmr_load    = 1'b1;
                            tmr_val     = len_minus_one(ctl_q.tl);
                        end
                    end
                end
                ST_TRANS: begin
                    if (tmr_expired) begin
                        ctl_d.sel   = next_sel;
                        ctl_d.dv    = pll_lock[next_sel];
                        ctl_d.err   = ctl_q.err | ~pll_lock[next_sel];
                        ctl_d.pre   = 1'b0;
                        ctl_d.state = ST_DWELL;
                        tmr_load    = 1'b1;
                        tmr_val     = len_minus_one(ctl_q.dl);
                    end
                end
                ST_DWELL: begin
                    if (tmr_expired) begin
                        ctl_d.dv    = 1'b0;
                        ctl_d.state = ST_TUNE;
                    end
                end
                default: ctl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    fh_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    fh_tune_issue #(.FREQ_W(FREQ_W)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .target     (target),
        .word       (freq_word),
        .tune_start (tune_start),
        .tune_word  (tune_word)
    );

    assign active_sel    = ctl_q.sel;
    assign dwell_valid   = ctl_q.dv;
    assign late_lock_err = ctl_q.err;
    assign mux_mode      = ctl_q.mux;

    // R3
    retune_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_mode |-> !active_sel);

    // R6
    dwell_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dwell_valid) |-> (active_sel ? $past(pll_lock[1]) : $past(pll_lock[0])));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (late_lock_err && ctl_q.state != ST_IDLE) |=> late_lock_err);

    // R8
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freq_ready |-> enable);

    // R10
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!dwell_valid && !freq_ready));

    // R9
    strobe_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_start != '0) |-> $past(accept));

endmodule

// File: tb/fh_pingpong_sched_test.sv
`timescale 1ns/1ps
module fh_pingpong_sched_test;

    localparam int CW = 6;
    localparam int FW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic [CW-1:0]     trans_len = '0;
    logic [CW-1:0]     dwell_len = '0;
    logic [CW-1:0]     retune_time = '0;
    logic              freq_valid = 1'b0;
    logic [FW-1:0]     freq_word = 12'h101;
    logic              freq_ready;
    logic [1:0]        pll_lock = 2'b11;
    logic [1:0]        tune_start;
    logic [1:0][FW-1:0] tune_word;
    logic              active_sel;
    logic              dwell_valid;
    logic              late_lock_err;
    logic              mux_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fh_pingpong_sched #(.CNT_W(CW), .FREQ_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .trans_len(trans_len), .dwell_len(dwell_len), .retune_time(retune_time),
        .freq_valid(freq_valid), .freq_word(freq_word), .freq_ready(freq_ready),
        .pll_lock(pll_lock), .tune_start(tune_start), .tune_word(tune_word),
        .active_sel(active_sel), .dwell_valid(dwell_valid),
        .late_lock_err(late_lock_err), .mux_mode(mux_mode)
    );

    // behavioural reference: 0 idle, 1 waiting for word, 2 transition, 3 dwell
    int      m_phase = 0;
    int      m_left = 0;
    int      m_tl = 0;
    int      m_dl = 0;
    bit      m_mux = 0, m_pre = 0, m_second = 0, m_sel = 0, m_dv = 0, m_err = 0;
    bit      m_acc = 0;
    bit [1:0] m_ts = 0;
    logic [1:0][FW-1:0] m_tw = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_mux = 0; m_pre = 0; m_second = 0; m_sel = 0;
            m_dv = 0; m_err = 0; m_ts = 0; m_tw = '0; m_acc = 0; m_left = 0;
        end else begin
            m_ts  = 0;
            m_acc = 0;
            if (!enable) begin
                m_phase = 0;
                m_dv    = 0;
            end else if (m_phase == 0) begin
                m_mux = (int'(trans_len) < int'(retune_time));
                m_tl  = (trans_len == 0) ? 1 : int'(trans_len);
                m_dl  = (dwell_len == 0) ? 1 : int'(dwell_len);
                m_err = 0; m_sel = 0; m_pre = 1; m_second = 0; m_dv = 0;
                m_phase = 1;
            end else if (m_phase == 1) begin
                if (freq_valid) begin
                    int t;
                    m_acc = 1;
                    if (m_pre) t = m_second ? 1 : 0;
                    else t = m_mux ? int'(m_sel) : 0;
                    m_ts[t] = 1'b1;
                    m_tw[t] = freq_word;
                    if (m_mux && m_pre && !m_second) m_second = 1;
                    else begin m_phase = 2; m_left = m_tl; end
                end
            end else if (m_phase == 2) begin
                if (m_left == 1) begin
                    if (!m_pre && m_mux) m_sel = !m_sel;
                    m_dv = pll_lock[m_sel];
                    if (!pll_lock[m_sel]) m_err = 1;
                    m_pre = 0;
                    m_phase = 3;
                    m_left = m_dl;
                end else m_left--;
            end else begin
                if (m_left == 1) begin
                    m_dv = 0;
                    m_phase = 1;
                end else m_left--;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R9", "tune_start", 64'(tune_start), 64'(m_ts));
        chk("R9", "tune_word0", 64'(tune_word[0]), 64'(m_tw[0]));
        chk("R4", "tune_word1", 64'(tune_word[1]), 64'(m_tw[1]));
        chk("R3", "active_sel", 64'(active_sel), 64'(m_sel));
        chk("R2", "dwell_valid", 64'(dwell_valid), 64'(m_dv));
        chk("R6", "late_lock_err", 64'(late_lock_err), 64'(m_err));
        chk("R8", "freq_ready", 64'(freq_ready), 64'((m_phase == 1) && enable));
        chk("R1", "mux_mode", 64'(mux_mode), 64'(m_mux));
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            if (m_acc) freq_word = freq_word + 12'h111;
        end
    endtask

    task automatic start(input int tl, input int dl, input int rt);
        enable = 1'b0;
        step(2);
        trans_len = CW'(tl); dwell_len = CW'(dl); retune_time = CW'(rt);
        enable = 1'b1;
        step(1);
    endtask

    initial begin
        // R11 reset state
        step(1);
        chk("R11", "reset tune_start", 64'(tune_start), 0);
        chk("R11", "reset dwell_valid", 64'(dwell_valid), 0);
        chk("R11", "reset mux_mode", 64'(mux_mode), 0);
        rst_n = 1'b1;
        freq_valid = 1'b1;
        step(2);

        // R1 equal lengths select retune mode; R4 all tunes to synthesizer 0
        start(4, 5, 4);
        chk("R1", "equal picks retune", 64'(mux_mode), 0);
        step(40);

        // R5 alternating preload, R3 toggling, R2 timing
        start(2, 6, 10);
        chk("R1", "shorter picks alternating", 64'(mux_mode), 1);
        step(50);

        // R8 word source stalls
        for (int k = 0; k < 6; k++) begin
            freq_valid = 1'b0;
            step(3);
            freq_valid = 1'b1;
            step(5);
        end

        // R6 synthesizer 1 never locks; R7 error persists
        pll_lock = 2'b01;
        step(30);
        pll_lock = 2'b11;
        step(20);
        chk("R7", "error sticky after recovery", 64'(late_lock_err), 1);

        // R10 disable mid-run, R7 survives disable, cleared on restart
        enable = 1'b0;
        step(3);
        chk("R10", "idle dwell_valid", 64'(dwell_valid), 0);
        chk("R7", "error kept while idle", 64'(late_lock_err), 1);

        // R2 zero and one lengths
        start(0, 0, 1);
        chk("R7", "error cleared on start", 64'(late_lock_err), 0);
        step(30);
        start(1, 1, 1);
        step(30);

        // R6 retune mode with synthesizer 0 unlocked
        pll_lock = 2'b10;
        start(3, 3, 2);
        step(20);
        pll_lock = 2'b11;
        step(10);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule